// File: doc/BRIEF.md
# Synchronous Burst SRAM Write Port

This block models a clocked, flow-through static RAM as a bus master sees it. Four byte lanes form each data word. Address and control inputs are captured on the rising clock. An internal two-bit counter steps through an aligned group of four words, so a master can issue one address and then stream several data beats.

Two address strobes open a burst. The processor strobe only loads the address, and the write controls are ignored on that clock. The controller strobe loads the address and can write on the same clock. On each later clock, the advance input either steps the internal address to the next word in the group or holds it. A held address lets the same word be written again. On every clock, the write controls pick the lanes that are written: the global write writes all four lanes, and the byte-write enable writes only the lanes whose enables are low. When neither is active, the clock is a read.

Read data flows through without a register. It is taken from the word at the current effective address, and a separate output-enable flag goes with it. The array depth is a parameter. The default of 9 address bits keeps elaboration small, and 15 address bits gives the full 32K-word organisation.

Top module: `sbr_sram_port`

## Requirements
- R1: The chip is selected only when `sel_a_n` is 0, `sel_b_n` is 0 and `sel_c` is 1. On a clock where either strobe is low but the chip is not selected, no lane is written and the internal address is held.
- R2: On a selected clock with `strobe_proc_n` low, no lane is written, whatever the values of `gwr_n`, `bwe_n` and `lane_en_n`. The address `addr_i` is loaded as the new burst address.
- R3: On a selected clock with `strobe_ctrl_n` low and `strobe_proc_n` high, `addr_i` is loaded, and the lanes chosen by the write controls are written at `addr_i` on that same clock. When both strobes are low, the processor strobe wins.
- R4: On a clock with both strobes high and `adv_n` high, after a load, the write goes to the held internal address. Holding `adv_n` high in the middle of a burst lets the same word be written again.
- R5: On a clock with both strobes high and `adv_n` low, the low two address bits count up by one, wrapping from 3 to 0. The upper bits stay as loaded, and any write that clock goes to the stepped address.
- R6: With `gwr_n` low, all four lanes are written, whatever `bwe_n` and `lane_en_n` are.
- R7: With `gwr_n` high and `bwe_n` low, lane i (data bits 8i+7 down to 8i) is written only when `lane_en_n[i]` is 0.
- R8: With `gwr_n` and `bwe_n` both high, nothing is written, and the clock is a read.
- R9: `rdata` combinationally shows the stored word at the effective address of the current clock, before that clock's write lands. `rdata_oe` equals the inverse of `oe_n`.
- R10: After reset, no burst is open, and no write takes place until a strobe loads an address. The array contents are not cleared by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset of the burst state |
| addr_i | input | ADDR_W | Word address loaded by a strobe |
| strobe_proc_n | input | 1 | Processor address strobe, active low, load only |
| strobe_ctrl_n | input | 1 | Controller address strobe, active low, load and write |
| adv_n | input | 1 | Burst advance, active low; high holds the address |
| gwr_n | input | 1 | Global write of all lanes, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| lane_en_n | input | 4 | Per-lane byte enables, active low |
| oe_n | input | 1 | Output enable, active low |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b_n | input | 1 | Second chip select, active low |
| sel_c | input | 1 | Third chip select, active high |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Flow-through read data |
| rdata_oe | output | 1 | Drive enable for `rdata` |

## Verification
Bursts are opened by both strobes, and each kind of opening is followed by different advance patterns:
- a straight run of four beats that crosses the group wrap, which would expose counter and upper-bit errors;
- a run with a held beat in the middle, which separates holding the address from stepping it;
- write beats on the load clock itself, which separate the two strobes.

Each write-control combination is tried with known old data already in the word:
- global write with lane enables that are not all low;
- byte writes with alternating lanes;
- a clock with no write at all.

A lane-mask fault then shows up as a wrong byte on the next read. Deselected strobes and write attempts made after a second reset are checked by reading the word they could have changed.

// File: rtl/sbr_pkg.sv
package sbr_pkg;

  localparam int LANES  = 4;
  localparam int LANE_W = 8;
  localparam int WORD_W = LANES * LANE_W;

  typedef enum logic [1:0] {
    CYC_CONT      = 2'd0,
    CYC_LOAD_PROC = 2'd1,
    CYC_LOAD_CTRL = 2'd2,
    CYC_IDLE      = 2'd3
  } cyc_e;

  function automatic logic chip_sel(input logic a_n, input logic b_n, input logic c);
    return !a_n && !b_n && c;
  endfunction

  function automatic logic [1:0] burst_next(input logic [1:0] cnt);
    return cnt + 2'd1;
  endfunction

  function automatic logic [LANES-1:0] lane_mask(input logic gwr_n, input logic bwe_n,
                                                 input logic [LANES-1:0] en_n);
    if (!gwr_n)      return '1;
    else if (!bwe_n) return ~en_n;
    else             return '0;
  endfunction

endpackage

// File: rtl/sbr_cycle_decode.sv
module sbr_cycle_decode
  import sbr_pkg::*;
(
  input  logic             strobe_proc_n,
  input  logic             strobe_ctrl_n,
  input  logic             adv_n,
  input  logic             gwr_n,
  input  logic             bwe_n,
  input  logic [LANES-1:0] lane_en_n,
  input  logic             sel_a_n,
  input  logic             sel_b_n,
  input  logic             sel_c,
  input  logic             active,
  output cyc_e             cyc,
  output logic             step,
  output logic [LANES-1:0] we_lanes
);

  logic selected;
  logic write_ok;

  always_comb begin
    selected = chip_sel(sel_a_n, sel_b_n, sel_c);
    if (!strobe_proc_n)      cyc = selected ? CYC_LOAD_PROC : CYC_IDLE;
    else if (!strobe_ctrl_n) cyc = selected ? CYC_LOAD_CTRL : CYC_IDLE;
    else                     cyc = CYC_CONT;
    write_ok = (cyc == CYC_LOAD_CTRL) || ((cyc == CYC_CONT) && active);
    we_lanes = write_ok ? lane_mask(gwr_n, bwe_n, lane_en_n) : '0;
    step     = (cyc == CYC_CONT) && active && !adv_n;
  end

endmodule

// File: rtl/sbr_burst_addr.sv
module sbr_burst_addr
  import sbr_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cyc_e              cyc,
  input  logic              step,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] eff_addr,
  output logic              active
);

  localparam int HI_W = ADDR_W - 2;

  logic [HI_W-1:0] hi_q;
  logic [1:0]      cnt_q;
  logic            active_q;
  logic            load;

  assign load   = (cyc == CYC_LOAD_PROC) || (cyc == CYC_LOAD_CTRL);
  assign active = active_q;

  always_comb begin
    if (load)      eff_addr = addr_i;
    else if (step) eff_addr = {hi_q, burst_next(cnt_q)};
    else           eff_addr = {hi_q, cnt_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q     <= '0;
      cnt_q    <= '0;
      active_q <= 1'b0;
    end else begin
      if (load) active_q <= 1'b1;
      hi_q  <= eff_addr[ADDR_W-1:2];
      cnt_q <= eff_addr[1:0];
    end
  end

  a_r5_step_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> cnt_q == $past(cnt_q) + 2'd1);
  a_r5_upper_held: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(hi_q));
  a_r4_suspend_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == CYC_CONT && !step) |=> $stable(cnt_q));
  a_r1_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == CYC_IDLE) |=> ($stable(cnt_q) && $stable(hi_q)));
  a_r3_load_taken: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> ({hi_q, cnt_q} == $past(addr_i)) && active_q);

endmodule

// File: rtl/sbr_lane_array.sv
module sbr_lane_array
  import sbr_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic [LANES-1:0]  we_lanes,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
      if (we_lanes[l]) store[addr] <= wdata[l*LANE_W +: LANE_W];
    end

    assign rdata[l*LANE_W +: LANE_W] = store[addr];
  end

endmodule

// File: rtl/sbr_sram_port.sv
module sbr_sram_port
  import sbr_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              strobe_proc_n,
  input  logic              strobe_ctrl_n,
  input  logic              adv_n,
  input  logic              gwr_n,
  input  logic              bwe_n,
  input  logic [3:0]        lane_en_n,
  input  logic              oe_n,
  input  logic              sel_a_n,
  input  logic              sel_b_n,
  input  logic              sel_c,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              rdata_oe
);

  cyc_e              cyc;
  logic              step;
  logic              active;
  logic [LANES-1:0]  we_lanes;
  logic [ADDR_W-1:0] eff_addr;

  sbr_cycle_decode u_decode (
    .strobe_proc_n (strobe_proc_n),
    .strobe_ctrl_n (strobe_ctrl_n),
    .adv_n         (adv_n),
    .gwr_n         (gwr_n),
    .bwe_n         (bwe_n),
    .lane_en_n     (lane_en_n),
    .sel_a_n       (sel_a_n),
    .sel_b_n       (sel_b_n),
    .sel_c         (sel_c),
    .active        (active),
    .cyc           (cyc),
    .step          (step),
    .we_lanes      (we_lanes)
  );

  sbr_burst_addr #(.ADDR_W(ADDR_W)) u_addr (
    .clk      (clk),
    .rst_n    (rst_n),
    .cyc      (cyc),
    .step     (step),
    .addr_i   (addr_i),
    .eff_addr (eff_addr),
    .active   (active)
  );

  sbr_lane_array #(.ADDR_W(ADDR_W)) u_array (
    .clk      (clk),
    .we_lanes (we_lanes),
    .addr     (eff_addr),
    .wdata    (wdata),
    .rdata    (rdata)
  );

  assign rdata_oe = !oe_n;

  a_r2_proc_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe_proc_n) |-> (we_lanes == '0));
  a_r1_unselected_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    ((!strobe_proc_n || !strobe_ctrl_n) && !(!sel_a_n && !sel_b_n && sel_c)) |-> (we_lanes == '0));
  a_r6_global_all_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    (!gwr_n && we_lanes != '0) |-> (we_lanes == '1));
  a_r7_lane_subset: assert property (@(posedge clk) disable iff (!rst_n)
    (gwr_n && !bwe_n) |-> ((we_lanes & lane_en_n) == '0));
  a_r8_read_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (gwr_n && bwe_n) |-> (we_lanes == '0));
  a_r10_closed_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && strobe_ctrl_n) |-> (we_lanes == '0));

endmodule

// File: tb/test_sbr_sram_port.sv
module test_sbr_sram_port;

  localparam int AW = 9;
  localparam logic [2:0] ON = 3'b001;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] addr_i;
  logic          strobe_proc_n, strobe_ctrl_n, adv_n, gwr_n, bwe_n, oe_n;
  logic [3:0]    lane_en_n;
  logic          sel_a_n, sel_b_n, sel_c;
  logic [31:0]   wdata, rdata;
  logic          rdata_oe;

  int checks = 0;
  int errors = 0;

  logic [31:0] mdat [int];
  int  m_addr;
  bit  m_open;

  always #5 clk = ~clk;

  sbr_sram_port #(.ADDR_W(AW)) i_sbr_sram_port (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i),
    .strobe_proc_n(strobe_proc_n), .strobe_ctrl_n(strobe_ctrl_n), .adv_n(adv_n),
    .gwr_n(gwr_n), .bwe_n(bwe_n), .lane_en_n(lane_en_n), .oe_n(oe_n),
    .sel_a_n(sel_a_n), .sel_b_n(sel_b_n), .sel_c(sel_c),
    .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe)
  );

  task automatic check(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", rq, act, exp, $time);
    end
  endtask

  task automatic idle_inputs();
    strobe_proc_n = 1; strobe_ctrl_n = 1; adv_n = 1; gwr_n = 1; bwe_n = 1;
    lane_en_n = 4'hF; oe_n = 1; sel_a_n = 1; sel_b_n = 1; sel_c = 0;
    addr_i = '0; wdata = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    idle_inputs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    m_open = 0;
    m_addr = 0;
  endtask

  // One clock: drive, predict, compare the combinational outputs, then commit the model.
  task automatic beat(input bit sp, input bit sc, input bit adv, input bit gw, input bit bwe,
                      input logic [3:0] be, input bit oe, input logic [2:0] cs,
                      input int a, input logic [31:0] d, input string rq);
    bit sel, ldp, ldc, idle, wr;
    int e;
    logic [3:0] mask;
    logic [31:0] w;
    @(negedge clk);
    strobe_proc_n = sp; strobe_ctrl_n = sc; adv_n = adv; gwr_n = gw; bwe_n = bwe;
    lane_en_n = be; oe_n = oe; {sel_a_n, sel_b_n, sel_c} = cs;
    addr_i = AW'(a); wdata = d;
    sel  = (cs == ON);
    ldp  = !sp && sel;
    ldc  = sp && !sc && sel;
    idle = (!sp || !sc) && !sel;
    if (ldp || ldc) e = a;
    else if (!idle && m_open && !adv) e = (m_addr & ~3) | ((m_addr + 1) & 3);
    else e = m_addr;
    if (!gw) mask = 4'hF;
    else if (!bwe) mask = ~be;
    else mask = 4'h0;
    wr = ldc || (m_open && !sp ? 1'b0 : (m_open && sp && sc));
    if (!wr) mask = 4'h0;
    #2;
    check(rdata_oe == !oe, {rq, " rdata_oe"}, {31'd0, rdata_oe}, {31'd0, !oe});
    if (!oe && mdat.exists(e)) check(rdata == mdat[e], {rq, " rdata"}, rdata, mdat[e]);
    @(posedge clk);
    #1;
    if (mask != 4'h0) begin
      if (mdat.exists(e) || mask == 4'hF) begin
        w = mdat.exists(e) ? mdat[e] : 32'h0;
        for (int l = 0; l < 4; l++) if (mask[l]) w[8*l +: 8] = d[8*l +: 8];
        mdat[e] = w;
      end
    end
    if (ldp || ldc) m_open = 1;
    m_addr = e;
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    idle_inputs();
    rst_n = 0;
    do_reset();
    // R10: reset state, output enable off
    beat(1,1,1,1,1,4'hF,1,ON,0,0,"R10");
    // R3/R6: controller-strobe writes on the load clock
    beat(1,0,1,0,1,4'hF,1,ON,'h10,32'hA5A5_0001,"R3");
    beat(1,0,1,0,1,4'hF,1,ON,'h21,32'h1111_2222,"R3");
    beat(1,0,1,0,1,4'hF,1,ON,'h00,32'hC0DE_0000,"R3");
    beat(1,0,1,0,1,4'hF,1,ON,'h35,32'h0BAD_0035,"R3");
    // R9: flow-through read, then output enable off
    beat(1,0,1,1,1,4'hF,0,ON,'h10,0,"R9");
    beat(1,1,1,1,1,4'hF,0,ON,0,0,"R9");
    beat(1,1,1,1,1,4'hF,1,ON,0,0,"R9");
    // R2: processor strobe with every write control low writes nothing
    beat(0,1,1,0,0,4'h0,1,ON,'h21,32'hDEAD_BEEF,"R2");
    beat(1,1,1,1,1,4'hF,0,ON,0,0,"R2");
    // R4/R5: burst from a processor load, crossing the group wrap
    beat(0,1,1,1,1,4'hF,1,ON,'h21,0,"R4");
    beat(1,1,1,0,1,4'hF,1,ON,0,32'hB000_0021,"R4");
    beat(1,1,0,0,1,4'hF,1,ON,0,32'hB000_0022,"R5");
    beat(1,1,0,0,1,4'hF,1,ON,0,32'hB000_0023,"R5");
    beat(1,1,0,0,1,4'hF,1,ON,0,32'hB000_0020,"R5");
    beat(1,0,1,1,1,4'hF,0,ON,'h21,0,"R5");
    for (int i = 0; i < 4; i++) beat(1,1,0,1,1,4'hF,0,ON,0,0,"R5");
    // R4: suspended burst rewrites the held word
    beat(0,1,1,1,1,4'hF,1,ON,'h34,0,"R4");
    beat(1,1,1,0,1,4'hF,1,ON,0,32'hE000_0034,"R4");
    beat(1,1,0,0,1,4'hF,1,ON,0,32'hE100_0035,"R4");
    beat(1,1,1,0,1,4'hF,1,ON,0,32'hE200_0035,"R4");
    beat(1,1,0,0,1,4'hF,1,ON,0,32'hE300_0036,"R4");
    beat(1,0,1,1,1,4'hF,0,ON,'h34,0,"R4");
    beat(1,1,0,1,1,4'hF,0,ON,0,0,"R4");
    beat(1,1,0,1,1,4'hF,0,ON,0,0,"R4");
    // R7/R8/R6: lane selection
    beat(1,0,1,0,1,4'hF,1,ON,'h40,32'hFFFF_FFFF,"R6");
    beat(0,1,1,1,1,4'hF,1,ON,'h40,0,"R7");
    beat(1,1,1,1,0,4'b1010,1,ON,0,32'h1122_3344,"R7");
    beat(1,1,1,1,1,4'h0,0,ON,0,32'h0,"R8");
    beat(1,1,1,1,1,4'hF,0,ON,0,0,"R8");
    beat(1,1,1,0,1,4'b0101,1,ON,0,32'h5566_7788,"R6");
    beat(1,1,1,1,1,4'hF,0,ON,0,0,"R6");
    beat(1,1,1,1,0,4'b0011,1,ON,0,32'hAABB_CCDD,"R7");
    beat(1,1,1,1,1,4'hF,0,ON,0,0,"R7");
    // R3: both strobes low, processor strobe wins, no write
    beat(1,0,1,1,1,4'hF,0,ON,'h10,0,"R3");
    beat(0,0,1,0,1,4'hF,1,ON,'h10,32'h0000_0BAD,"R3");
    beat(1,1,1,1,1,4'hF,0,ON,0,0,"R3");
    // R1: unselected strobes write nothing and keep the address
    beat(1,0,1,0,0,4'h0,1,3'b011,'h40,32'h1234_5678,"R1");
    beat(1,0,1,0,0,4'h0,1,3'b000,'h40,32'h1234_5678,"R1");
    beat(0,1,1,0,0,4'h0,1,3'b101,'h40,32'h1234_5678,"R1");
    beat(1,1,1,1,1,4'hF,0,ON,0,0,"R1");
    beat(1,0,1,1,1,4'hF,0,ON,'h40,0,"R1");
    // R10: after a second reset, writes without a load are dropped
    do_reset();
    beat(1,1,1,0,1,4'hF,1,ON,0,32'hFACE_0001,"R10");
    beat(1,1,0,0,0,4'h0,1,ON,0,32'hFACE_0002,"R10");
    beat(1,0,1,1,1,4'hF,0,ON,'h00,0,"R10");
    beat(1,0,1,1,1,4'hF,0,ON,'h35,0,"R10");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule